// File: doc/BRIEF.md
# Auto-Incrementing Configuration Register Loader

This block is the byte-wide load port for a bank of nineteen 16-bit configuration registers. An external controller drives a slow strobe together with a cycle-type select, a byte select and an 8-bit data byte. Each falling edge of the strobe is one load cycle. That cycle is either an address cycle, which sets the register pointer, or a data cycle, which writes one byte of the register the pointer selects.

The port has two modes.

- **Manual mode.** The byte select picks the half of the register that a data cycle writes, and the pointer stays where it is.
- **Auto mode.** An address cycle taken with the byte select high enters auto mode and records a starting address. Data cycles then fill the low byte first and the high byte next. After each high byte the pointer steps by one. After the last register the pointer returns to the recorded start rather than to zero.

In auto mode the whole bank loads in 39 cycles, against 57 cycles when every byte is addressed by hand.

The strobe is asynchronous to the system clock. It is synchronized and edge-detected inside the block. The select and data inputs must be held stable from the strobe's falling edge until four clocks after it. Every write raises a one-cycle strobe for the register written, and all register contents are visible on one flat output.

Top module: `cfg_load_port`

## Requirements
- R1: Reset clears every register to 0. It leaves the port in manual mode with the pointer at 0, so a data cycle issued before any address cycle writes register 0.
- R2: Only a falling edge of `load_i` starts a cycle, and it starts exactly one. Rising edges, a held low level and changes on the other inputs while `load_i` is high leave every register unchanged. The new value appears on `regs_o` at the third rising clock edge after `load_i` falls.
- R3: A cycle with `sel_data_i`=0 is an address cycle. With `sel_high_i`=0 it selects manual mode and loads `data_i` into the pointer. In manual mode, a data cycle (`sel_data_i`=1) writes `data_i` to bits [7:0] of the selected register when `sel_high_i`=0, and to bits [15:8] when `sel_high_i`=1. The other byte is left unchanged.
- R4: In manual mode the pointer does not move on data cycles, so repeated data cycles hit the same register.
- R5: A data cycle while the pointer is above 18 writes nothing and raises no write strobe.
- R6: An address cycle with `sel_high_i`=1 enters auto mode. It loads `data_i` both as the pointer and as the wrap start, and it makes the next data cycle a low-byte write.
- R7: In auto mode, data cycles alternate between the low byte and the high byte, starting with the low byte. `sel_high_i` is ignored during these cycles.
- R8: In auto mode the pointer increases by one on each high-byte data cycle, and only on those cycles.
- R9: A high-byte write at pointer 18 or above sends the pointer back to the wrap start. A start of 15 therefore visits 15, 16, 17, 18, 15 and so on.
- R10: A wrap start of 18 or more keeps the pointer on that value. Start 18 writes register 18 over and over; a start above 18 writes nothing.
- R11: `wr_en_o` bit i is high for exactly one clock per byte written to register i. It is high in the same cycle that the new value first appears on `regs_o`, and at most one bit is ever high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| load_i | input | 1 | Asynchronous load strobe, idle high; a falling edge starts a cycle |
| sel_data_i | input | 1 | 0 = address cycle, 1 = data cycle |
| sel_high_i | input | 1 | In an address cycle: 1 enters auto mode. In a manual data cycle: 1 selects the high byte |
| data_i | input | 8 | Address or data byte |
| wr_en_o | output | 19 | One-cycle write strobe per register |
| regs_o | output | 304 | Register contents; register i occupies bits [16*i+15:16*i] |

## Verification
The bench loads the whole bank three ways: manually with a distinct pattern per byte, in auto mode from start 0 while `sel_high_i` toggles, and by hand again to confirm the return to manual mode.

It then goes after the pointer corner cases:

- **Wrap from start 15.** A design that wraps to zero would overwrite registers 0 and 1 instead of register 15.
- **Pinned start 18.** A design that does not pin the pointer would run into registers beyond the bank.
- **Start 25.** A design that clamps rather than ignores would corrupt register 18.
- **Strobe held low for many clocks.** A level-sensitive design would write both bytes, or one byte repeatedly, instead of exactly one low byte.

Write-strobe counts per register confirm that out-of-range cycles raise no strobe and that each byte write raises exactly one.

// File: rtl/cfg_load_port.sv
module cfg_load_port #(
  parameter int NUM_REGS    = 19,
  parameter int BYTE_W      = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic                           load_i,
  input  logic                           sel_data_i,
  input  logic                           sel_high_i,
  input  logic [BYTE_W-1:0]              data_i,
  output logic [NUM_REGS-1:0]            wr_en_o,
  output logic [NUM_REGS*2*BYTE_W-1:0]   regs_o
);

  localparam int REG_W = 2 * BYTE_W;
  localparam logic [BYTE_W-1:0] LAST_A = BYTE_W'(NUM_REGS - 1);

  // strobe synchronizer and falling-edge detect
  logic [SYNC_STAGES-1:0] sync_q;
  logic                   load_prev_q;
  logic                   fall;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sync_q      <= '1;
      load_prev_q <= 1'b1;
    end else begin
      sync_q      <= {sync_q[SYNC_STAGES-2:0], load_i};
      load_prev_q <= sync_q[SYNC_STAGES-1];
    end
  end

  assign fall = load_prev_q & ~sync_q[SYNC_STAGES-1];

  // pointer, wrap start, mode and byte phase
  logic [BYTE_W-1:0] addr_q, start_q, next_addr;
  logic              auto_q, phase_q;
  logic              addr_cyc, data_cyc, in_range, wr_hi, we, adv;

  assign addr_cyc  = fall & ~sel_data_i;
  assign data_cyc  = fall & sel_data_i;
  assign in_range  = addr_q <= LAST_A;
  assign wr_hi     = auto_q ? phase_q : sel_high_i;
  assign we        = data_cyc & in_range;
  assign adv       = data_cyc & auto_q & phase_q;
  assign next_addr = (addr_q >= LAST_A) ? start_q : addr_q + 1'b1;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      addr_q  <= '0;
      start_q <= '0;
      auto_q  <= 1'b0;
      phase_q <= 1'b0;
    end else if (addr_cyc) begin
      addr_q  <= data_i;
      start_q <= data_i;
      auto_q  <= sel_high_i;
      phase_q <= 1'b0;
    end else if (data_cyc && auto_q) begin
      phase_q <= ~phase_q;
      if (adv) addr_q <= next_addr;
    end
  end

  // register bank
  logic [REG_W-1:0] regs_q [NUM_REGS];

  for (genvar i = 0; i < NUM_REGS; i++) begin : g_reg
    logic hit;
    assign hit = we && (addr_q == BYTE_W'(i));

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        regs_q[i]  <= '0;
        wr_en_o[i] <= 1'b0;
      end else begin
        wr_en_o[i] <= hit;
        if (hit) begin
          if (wr_hi) regs_q[i][REG_W-1:BYTE_W] <= data_i;
          else       regs_q[i][BYTE_W-1:0]     <= data_i;
        end
      end
    end

    assign regs_o[i*REG_W +: REG_W] = regs_q[i];
  end

  // checks
  assert_single_strobe_R11: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(wr_en_o));

  assert_quiet_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !fall |=> $stable(regs_o) && (wr_en_o == '0));

  assert_manual_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (data_cyc && !auto_q) |=> $stable(addr_q));

  assert_ignore_high_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (data_cyc && !in_range) |=> (wr_en_o == '0) && $stable(regs_o));

  assert_advance_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (adv && addr_q < LAST_A) |=> addr_q == $past(addr_q) + 1'b1);

  assert_wrap_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (adv && addr_q >= LAST_A) |=> addr_q == start_q);

endmodule

// File: tb/cfg_load_port_tb.sv
module cfg_load_port_tb_top;
  localparam int CLK_P = 10;
  localparam int N     = 19;

  logic clk = 1'b0, rst_n = 1'b0, load_i = 1'b1, sel_data_i = 1'b0, sel_high_i = 1'b0;
  logic [7:0] data_i = '0;
  logic [N-1:0] wr_en_o;
  logic [N*16-1:0] regs_o;

  cfg_load_port dut_i (.clk(clk), .rst_n(rst_n), .load_i(load_i), .sel_data_i(sel_data_i),
    .sel_high_i(sel_high_i), .data_i(data_i), .wr_en_o(wr_en_o), .regs_o(regs_o));

  always #(CLK_P/2) clk = ~clk;

  int vectors = 0, errors = 0;
  bit done = 0;
  logic [15:0] exp_r [N];
  int wr_cnt [N];
  int m_addr, m_start;
  bit m_auto, m_phase;

  always @(negedge clk) begin
    if (rst_n) begin
      if ($countones(wr_en_o) > 1) begin
        errors++;
        $display("FAIL R11 strobe not one-hot: act %b exp at most one bit", wr_en_o);
      end
      for (int i = 0; i < N; i++) if (wr_en_o[i]) wr_cnt[i]++;
    end
  end

  task automatic chk(input string req, input int act, input int exp);
    vectors++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: act %0h exp %0h", req, act, exp);
    end
  endtask

  task automatic check_all(input string req);
    for (int i = 0; i < N; i++) chk(req, int'(regs_o[i*16 +: 16]), int'(exp_r[i]));
  endtask

  task automatic clear_cnt();
    for (int i = 0; i < N; i++) wr_cnt[i] = 0;
  endtask

  task automatic pulse(input bit sd, input bit sh, input logic [7:0] d, input int low_cyc);
    @(negedge clk);
    sel_data_i = sd; sel_high_i = sh; data_i = d;
    @(negedge clk);
    load_i = 1'b0;
    repeat (low_cyc) @(negedge clk);
    load_i = 1'b1;
    repeat (4) @(negedge clk);
  endtask

  task automatic addr_cyc(input logic [7:0] a, input bit auto_m);
    pulse(1'b0, auto_m, a, 5);
    m_addr = a; m_start = a; m_auto = auto_m; m_phase = 0;
  endtask

  task automatic data_cyc(input logic [7:0] d, input bit hi, input int low_cyc = 5);
    bit h;
    pulse(1'b1, hi, d, low_cyc);
    h = m_auto ? m_phase : hi;
    if (m_addr <= 18) begin
      if (h) exp_r[m_addr][15:8] = d;
      else   exp_r[m_addr][7:0]  = d;
    end
    if (m_auto) begin
      if (m_phase) m_addr = (m_addr >= 18) ? m_start : m_addr + 1;
      m_phase = ~m_phase;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++; vectors++;
      $display("FAIL watchdog: act timeout exp completion");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < N; i++) exp_r[i] = '0;
    m_addr = 0; m_start = 0; m_auto = 0; m_phase = 0;
    clear_cnt();
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state and pointer at 0
    check_all("R1 reset");
    chk("R1 strobes idle", int'(wr_en_o), 0);
    data_cyc(8'h5A, 1'b0);
    check_all("R1 first data lands in reg 0");

    // R2 activity while strobe is high does nothing
    for (int k = 0; k < 6; k++) begin
      @(negedge clk); sel_data_i = k[0]; sel_high_i = k[1]; data_i = 8'(k * 37);
    end
    repeat (4) @(negedge clk);
    check_all("R2 no edge no write");

    // R3 manual sweep, R11 strobe counts
    clear_cnt();
    for (int i = 0; i < N; i++) begin
      addr_cyc(8'(i), 1'b0);
      data_cyc(8'(i * 7 + 3), 1'b0);
      data_cyc(8'(8'hC0 ^ i), 1'b1);
    end
    check_all("R3 manual sweep");
    for (int i = 0; i < N; i++) chk("R11 two strobes per reg", wr_cnt[i], 2);

    // R4 no advance in manual mode
    addr_cyc(8'd5, 1'b0);
    data_cyc(8'h11, 1'b0);
    data_cyc(8'h22, 1'b0);
    check_all("R4 manual pointer holds");

    // R5 out-of-range manual pointer
    clear_cnt();
    addr_cyc(8'd19, 1'b0);
    data_cyc(8'hEE, 1'b0);
    addr_cyc(8'd200, 1'b0);
    data_cyc(8'hDD, 1'b1);
    check_all("R5 out of range ignored");
    for (int i = 0; i < N; i++) chk("R5 no strobe", wr_cnt[i], 0);

    // R6 R7 R8 auto from 0 with byte select toggling
    clear_cnt();
    addr_cyc(8'd0, 1'b1);
    for (int j = 0; j < 2 * N; j++) data_cyc(8'(j * 13 + 1), j[1]);
    check_all("R7 R8 auto full load");
    for (int i = 0; i < N; i++) chk("R11 auto strobe count", wr_cnt[i], 2);

    // R2 strobe held low for many clocks counts once
    addr_cyc(8'd3, 1'b1);
    data_cyc(8'h77, 1'b1, 14);
    check_all("R2 held low single write");
    data_cyc(8'h88, 1'b0);
    check_all("R7 high follows low");

    // R9 wrap from 15
    addr_cyc(8'd15, 1'b1);
    for (int j = 0; j < 10; j++) data_cyc(8'(8'hA0 + j), 1'b0);
    check_all("R9 wrap to start 15");
    chk("R9 reg15 rewritten", int'(regs_o[15*16 +: 16]), 16'hA9A8);

    // R10 pinned starts
    clear_cnt();
    addr_cyc(8'd18, 1'b1);
    for (int j = 0; j < 6; j++) data_cyc(8'(8'h30 + j), 1'b1);
    check_all("R10 start 18 pinned");
    chk("R10 reg18 strobes", wr_cnt[18], 6);
    clear_cnt();
    addr_cyc(8'd25, 1'b1);
    for (int j = 0; j < 4; j++) data_cyc(8'(8'h60 + j), 1'b0);
    check_all("R10 start 25 writes nothing");
    for (int i = 0; i < N; i++) chk("R10 no strobe", wr_cnt[i], 0);

    // R3 return to manual mode
    addr_cyc(8'd2, 1'b0);
    data_cyc(8'h4C, 1'b1);
    data_cyc(8'h4D, 1'b1);
    check_all("R3 back to manual");

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end
endmodule